// File: doc/BRIEF.md
# Graphics command packet framer

This block sits between a command-word source and a drawing engine. Command words arrive one at a time over a valid/ready handshake. The block groups them into whole packets, using a length that it looks up from the opcode in bits 31:24 of each packet's first word. Only after the last word of a packet has arrived does it send the packet on to the drawing port. The packet leaves one word per cycle, with start and end markers. While a packet is being sent, the input is stalled.

When a packet is complete, the block looks ahead into it before sending it on. Certain opcodes carry texture-page and drawing-mode state in known argument words. The block copies that state into a 13-bit status field that other logic can read.

Two opcodes ask for a block transfer to or from image memory. These packets are not forwarded. Instead, their position and size words are decoded and handed to a transfer engine. For a write transfer, the incoming words that follow carry the pixel payload. Those words go straight to the transfer engine's write port until the payload is complete, and then framing resumes.

Top module: `cmd_framer`

## Requirements
- R1: A packet is 1 + N words long, where N depends on the opcode in word 0 bits 31:24. N = 2 for 0x02, 0x40–0x43, 0x60–0x63, 0x6C–0x6F, 0x74–0x77, 0x7C–0x7F, 0xA0 and 0xC0. N = 3 for 0x20–0x23, 0x48–0x53, 0x64–0x67 and 0x80. N = 1 for 0x68–0x6B, 0x70–0x73 and 0x78–0x7B. N = 4 for 0x28–0x2B and 0x58–0x5F. N = 5 for 0x30–0x33, 6 for 0x24–0x27, 7 for 0x38–0x3B, 8 for 0x2C–0x2F and 0x34–0x37, and 11 for 0x3C–0x3F. Every other opcode has N = 0.
- R2: A complete packet (other than 0xA0 and 0xC0) leaves on `pkt_data` on consecutive cycles, in arrival order. `pkt_sop` is high only with the first word and `pkt_eop` only with the last. `in_ready` is low while a packet is leaving.
- R3: A packet whose words have not all arrived produces no output word, however long the gap before its remaining words.
- R4: When (opcode & 0xF4) == 0x24, status bits 8:0 take bits 8:0 of packet word 4. Status bits 12:9 are kept.
- R5: When (opcode & 0xF4) == 0x34, status bits 8:0 take bits 8:0 of packet word 5. Word 4 is ignored.
- R6: Opcode 0xE1 (one word) sets status bits 10:0 to bits 10:0 of its word. Bits 12:11 are kept.
- R7: Opcode 0xE6 (one word) sets status bits 12:11 to bits 1:0 of its word. Bits 10:0 are kept.
- R8: Opcodes 0xA0 (write) and 0xC0 (read) are never forwarded. Their completion pulses `xfer_start` for one cycle, with `xfer_read` = 1 for 0xC0. The fields come from the position word (word 1) and the size word (word 2): x = position bits 9:0, y = position bits 24:16, w = size bits 15:0, h = size bits 31:16.
- R9: After a write transfer with w*h > 0, the next ceil(w*h/2) accepted words appear only on the transfer write port and are not framed. A read transfer, or a write with w*h = 0, routes no words, and the next word is framed.
- R10: After reset, `in_ready` is 1, `pkt_valid` is 0, `xfer_start` is 0 and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command or payload word |
| in_ready | output | 1 | Block accepts a word this cycle |
| pkt_valid | output | 1 | Output packet word valid |
| pkt_data | output | 32 | Output packet word |
| pkt_sop | output | 1 | First word of a packet |
| pkt_eop | output | 1 | Last word of a packet |
| stat_bits | output | 13 | Snooped texture-page, draw-mode and mask state |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 = read |
| xfer_x | output | 10 | Transfer X position |
| xfer_y | output | 9 | Transfer Y position |
| xfer_w | output | 16 | Transfer width |
| xfer_h | output | 16 | Transfer height |
| xfer_wvalid | output | 1 | Payload word valid for the transfer engine |
| xfer_wdata | output | 32 | Payload word for the transfer engine |

## Verification
The bench tests the length lookup with packets of 1, 3, 4, 5, 7 and 12 words. These include opcodes at group boundaries and zero-argument gaps such as 0x44 and 0x54, so an off-by-one in the table or in the terminal count shows up as a wrong word count or a misplaced end marker.

A packet held half-finished for twenty idle cycles separates true holding from early forwarding. A shaded textured packet carries a decoy value in word 4, which separates a word-5 snoop from a word-4 snoop.

The write-transfer cases use both an even and an odd pixel count, and one payload word that looks like a draw-mode command. This shows that payload is routed, not framed, and that framing restarts on exactly the right word. Read transfers and zero-height transfers show that framing resumes at once.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    localparam int unsigned OP_W   = 8;
    localparam int unsigned STAT_W = 13;

    localparam logic [OP_W-1:0] OP_DRAWMODE = 8'hE1;
    localparam logic [OP_W-1:0] OP_MASKSET  = 8'hE6;
    localparam logic [OP_W-1:0] OP_VRAM_WR  = 8'hA0;
    localparam logic [OP_W-1:0] OP_VRAM_RD  = 8'hC0;

    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_EMIT    = 1'b1
    } cfr_state_e;

    typedef struct packed {
        logic        rd;
        logic [9:0]  x;
        logic [8:0]  y;
        logic [15:0] w;
        logic [15:0] h;
    } xfer_desc_t;

    // Number of argument words that follow the opcode word.
    function automatic logic [3:0] arg_count(input logic [OP_W-1:0] op);
        logic [3:0] n;
        case (op[7:2])
            6'h08: n = 4'd3;
            6'h09: n = 4'd6;
            6'h0A: n = 4'd4;
            6'h0B: n = 4'd8;
            6'h0C: n = 4'd5;
            6'h0D: n = 4'd8;
            6'h0E: n = 4'd7;
            6'h0F: n = 4'd11;
            6'h10: n = 4'd2;
            6'h12, 6'h13, 6'h14: n = 4'd3;
            6'h16, 6'h17: n = 4'd4;
            6'h18: n = 4'd2;
            6'h19: n = 4'd3;
            6'h1A, 6'h1C, 6'h1E: n = 4'd1;
            6'h1B, 6'h1D, 6'h1F: n = 4'd2;
            default: n = 4'd0;
        endcase
        if (op == 8'h02 || op == OP_VRAM_WR || op == OP_VRAM_RD) n = 4'd2;
        if (op == 8'h80) n = 4'd3;
        return n;
    endfunction

endpackage

// File: rtl/cfr_status.sv
module cfr_status
    import cfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [OP_W-1:0]   op,
    input  logic [10:0]       w0_lo,
    input  logic [8:0]        w4_lo,
    input  logic [8:0]        w5_lo,
    output logic [STAT_W-1:0] stat
);

    logic flat_tex, shaded_tex;
    assign flat_tex   = (op & 8'hF4) == 8'h24;
    assign shaded_tex = (op & 8'hF4) == 8'h34;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (upd) begin
            if (flat_tex)                stat[8:0]   <= w4_lo;
            else if (shaded_tex)         stat[8:0]   <= w5_lo;
            else if (op == OP_DRAWMODE)  stat[10:0]  <= w0_lo;
            else if (op == OP_MASKSET)   stat[12:11] <= w0_lo[1:0];
        end
    end

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(stat));

    // R7
    mask_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_MASKSET) |=> stat[10:0] == $past(stat[10:0]));

    // R4
    tex_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && (flat_tex || shaded_tex)) |=> stat[12:9] == $past(stat[12:9]));

endmodule

// File: rtl/cfr_xfer.sv
module cfr_xfer
    import cfr_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       wid,
    input  logic [15:0]       hgt,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              active,
    output logic              wvalid,
    output logic [WORD_W-1:0] wdata
);

    localparam int unsigned REM_W = 32;

    logic [REM_W-1:0] rem;
    logic [REM_W-1:0] pix;
    logic [REM_W:0]   pix_rnd;

    assign pix     = {16'b0, wid} * {16'b0, hgt};
    assign pix_rnd = {1'b0, pix} + {{REM_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (start) begin
            rem <= pix_rnd[REM_W:1];
        end else if (active && in_valid) begin
            rem <= rem - REM_W'(1);
        end
    end

    assign active = rem != '0;
    assign wvalid = active && in_valid;
    assign wdata  = in_data;

    // R9
    xfer_end_on_word_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(in_valid));

    // R9
    xfer_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> !start);

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
    import cfr_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned MAX_PKT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              pkt_valid,
    output logic [WORD_W-1:0] pkt_data,
    output logic              pkt_sop,
    output logic              pkt_eop,
    output logic [STAT_W-1:0] stat_bits,
    output logic              xfer_start,
    output logic              xfer_read,
    output logic [9:0]        xfer_x,
    output logic [8:0]        xfer_y,
    output logic [15:0]       xfer_w,
    output logic [15:0]       xfer_h,
    output logic              xfer_wvalid,
    output logic [WORD_W-1:0] xfer_wdata
);

    localparam int unsigned IDX_W = $clog2(MAX_PKT + 1);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    cfr_state_e        state;
    logic [IDX_W-1:0]  cnt, len_r, eidx, cur_len;
    logic [WORD_W-1:0] buf_q [MAX_PKT];
    logic              xa, take, last, is_vram;
    logic [OP_W-1:0]   op_c;
    logic [WORD_W-1:0] w4_v, w5_v;
    xfer_desc_t        desc_c, desc_q;
    logic              xs_q;

    assign in_ready = state == ST_COLLECT;
    assign take     = in_valid && in_ready && !xa;
    assign op_c     = (cnt == '0) ? in_data[31:24] : buf_q[0][31:24];
    assign cur_len  = (cnt == '0) ? IDX_W'(arg_count(in_data[31:24])) + ONE : len_r;
    assign last     = take && (cnt == cur_len - ONE);
    assign is_vram  = op_c == OP_VRAM_WR || op_c == OP_VRAM_RD;

    assign w4_v = (cnt == IDX_W'(4)) ? in_data : buf_q[4];
    assign w5_v = (cnt == IDX_W'(5)) ? in_data : buf_q[5];

    always_comb begin
        desc_c.rd = op_c == OP_VRAM_RD;
        desc_c.x  = buf_q[1][9:0];
        desc_c.y  = buf_q[1][24:16];
        desc_c.w  = in_data[15:0];
        desc_c.h  = in_data[31:16];
    end

    // packet word store
    always_ff @(posedge clk) begin
        if (take) buf_q[cnt] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_COLLECT;
            cnt    <= '0;
            len_r  <= '0;
            eidx   <= '0;
            xs_q   <= 1'b0;
            desc_q <= '0;
        end else begin
            xs_q <= 1'b0;
            if (take) begin
                if (cnt == '0) len_r <= cur_len;
                if (last) begin
                    cnt <= '0;
                    if (is_vram) begin
                        xs_q   <= 1'b1;
                        desc_q <= desc_c;
                    end else begin
                        state <= ST_EMIT;
                        eidx  <= '0;
                    end
                end else begin
                    cnt <= cnt + ONE;
                end
            end
            if (state == ST_EMIT) begin
                eidx <= eidx + ONE;
                if (eidx == len_r - ONE) state <= ST_COLLECT;
            end
        end
    end

    assign pkt_valid = state == ST_EMIT;
    assign pkt_data  = buf_q[eidx];
    assign pkt_sop   = pkt_valid && eidx == '0;
    assign pkt_eop   = pkt_valid && eidx == len_r - ONE;

    assign xfer_start = xs_q;
    assign xfer_read  = desc_q.rd;
    assign xfer_x     = desc_q.x;
    assign xfer_y     = desc_q.y;
    assign xfer_w     = desc_q.w;
    assign xfer_h     = desc_q.h;

    cfr_status u_status (
        .clk   (clk),
        .rst   (rst),
        .upd   (last && !is_vram),
        .op    (op_c),
        .w0_lo ((cnt == '0) ? in_data[10:0] : buf_q[0][10:0]),
        .w4_lo (w4_v[8:0]),
        .w5_lo (w5_v[8:0]),
        .stat  (stat_bits)
    );

    cfr_xfer #(.WORD_W(WORD_W)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .start    (last && op_c == OP_VRAM_WR),
        .wid      (desc_c.w),
        .hgt      (desc_c.h),
        .in_valid (in_valid),
        .in_data  (in_data),
        .active   (xa),
        .wvalid   (xfer_wvalid),
        .wdata    (xfer_wdata)
    );

    // R2
    emit_stall_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !in_ready);

    // R2
    emit_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_eop) |=> (pkt_valid && !pkt_sop));

    // R2
    emit_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_eop) |=> !pkt_valid);

    // R8
    vram_not_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> !pkt_valid);

    // R9
    route_excl_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_wvalid |-> !pkt_valid);

endmodule

// File: tb/test_cmd_framer.sv
module test_cmd_framer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, pkt_valid, pkt_sop, pkt_eop;
    logic [31:0] pkt_data;
    logic [12:0] stat_bits;
    logic        xfer_start, xfer_read, xfer_wvalid;
    logic [9:0]  xfer_x;
    logic [8:0]  xfer_y;
    logic [15:0] xfer_w, xfer_h;
    logic [31:0] xfer_wdata;

    always #5 clk = ~clk;

    cmd_framer i_cmd_framer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .stat_bits(stat_bits),
        .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_x(xfer_x),
        .xfer_y(xfer_y), .xfer_w(xfer_w), .xfer_h(xfer_h),
        .xfer_wvalid(xfer_wvalid), .xfer_wdata(xfer_wdata)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] pk_d [256];
    logic        pk_s [256];
    logic        pk_e [256];
    int          pk_n = 0;
    int          xs_n = 0;
    logic [51:0] xs_f;
    int          xw_n = 0;
    logic [31:0] xw_d [16];
    logic [31:0] wv [16];

    always @(negedge clk) begin
        if (!rst && pkt_valid && pk_n < 256) begin
            pk_d[pk_n] = pkt_data;
            pk_s[pk_n] = pkt_sop;
            pk_e[pk_n] = pkt_eop;
            pk_n++;
        end
        if (!rst && xfer_start) begin
            xs_n++;
            xs_f = {xfer_read, xfer_x, xfer_y, xfer_w, xfer_h};
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        if (xfer_wvalid && xw_n < 16) begin
            xw_d[xw_n] = xfer_wdata;
            xw_n++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_wv(input int n);
        for (int i = 0; i < n; i++) send(wv[i]);
    endtask

    task automatic expect_pkt(input int base, input int n, input string tag);
        idle(16);
        chk(pk_n - base == n, {tag, " word count"}, 64'(pk_n - base), 64'(n));
        for (int i = 0; i < n; i++) begin
            chk(pk_d[base+i] == wv[i], {tag, " data"}, 64'(pk_d[base+i]), 64'(wv[i]));
            chk(pk_s[base+i] == (i == 0), {tag, " sop"}, 64'(pk_s[base+i]), 64'(i == 0));
            chk(pk_e[base+i] == (i == n-1), {tag, " eop"}, 64'(pk_e[base+i]), 64'(i == n-1));
        end
    endtask

    task automatic one_pkt(input logic [7:0] op, input int n, input string tag);
        int base;
        base = pk_n;
        for (int i = 0; i < n; i++) wv[i] = (i == 0) ? {op, 24'h00_0000} : 32'h1000 + 32'(i);
        send_wv(n);
        expect_pkt(base, n, tag);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 1);
        chk(pkt_valid == 1'b0, "R10 pkt_valid", 64'(pkt_valid), 0);
        chk(xfer_start == 1'b0, "R10 xfer_start", 64'(xfer_start), 0);
        chk(stat_bits == 13'h0, "R10 status", 64'(stat_bits), 0);
    endtask

    task automatic t_drawmode();
        int base;
        base = pk_n;
        wv[0] = 32'hE100_0ABC;
        send_wv(1);
        expect_pkt(base, 1, "R6 R2 drawmode pkt");
        chk(stat_bits == 13'h02BC, "R6 status", 64'(stat_bits), 64'h02BC);
    endtask

    task automatic t_mask();
        int base;
        base = pk_n;
        wv[0] = 32'hE600_0003;
        send_wv(1);
        expect_pkt(base, 1, "R7 mask pkt");
        chk(stat_bits == 13'h1ABC, "R7 status", 64'(stat_bits), 64'h1ABC);
    endtask

    task automatic t_flat_poly();
        one_pkt(8'h20, 4, "R1 R2 op20");
        chk(stat_bits == 13'h1ABC, "R1 status untouched", 64'(stat_bits), 64'h1ABC);
    endtask

    task automatic t_tex_flat();
        int base;
        base = pk_n;
        for (int i = 0; i < 7; i++) wv[i] = 32'h0000_0100 + 32'(i);
        wv[0] = 32'h2500_0000;
        wv[4] = 32'h0000_FE55;
        send_wv(7);
        expect_pkt(base, 7, "R4 op25");
        chk(stat_bits == 13'h1A55, "R4 status", 64'(stat_bits), 64'h1A55);
    endtask

    task automatic t_tex_shaded();
        int base;
        base = pk_n;
        for (int i = 0; i < 12; i++) wv[i] = 32'h0000_0040 + 32'(i);
        wv[0] = 32'h3E00_0000;
        wv[4] = 32'h0000_01FF;
        wv[5] = 32'h0000_0123;
        send_wv(12);
        expect_pkt(base, 12, "R5 R1 op3E");
        chk(stat_bits == 13'h1B23, "R5 status from word 5", 64'(stat_bits), 64'h1B23);
    endtask

    task automatic t_hold();
        int base;
        base = pk_n;
        for (int i = 0; i < 5; i++) wv[i] = 32'h2A00_0000 + 32'(i);
        for (int i = 0; i < 3; i++) send(wv[i]);
        idle(20);
        chk(pk_n == base, "R3 held packet", 64'(pk_n - base), 0);
        chk(in_ready == 1'b1, "R3 still accepting", 64'(in_ready), 1);
        send(wv[3]);
        send(wv[4]);
        expect_pkt(base, 5, "R3 op2A released");
    endtask

    task automatic t_lengths();
        one_pkt(8'h44, 1, "R1 op44");
        one_pkt(8'h54, 1, "R1 op54");
        one_pkt(8'h76, 3, "R1 op76");
        one_pkt(8'h80, 4, "R1 op80");
        one_pkt(8'h02, 3, "R1 op02");
        one_pkt(8'h6B, 2, "R1 op6B");
    endtask

    task automatic t_vram_write();
        int base, xs0, xw0;
        base = pk_n; xs0 = xs_n; xw0 = xw_n;
        send(32'hA000_0000);
        send(32'h03F5_0123);
        send(32'h0002_0003);
        idle(3);
        chk(xs_n - xs0 == 1, "R8 write start pulse", 64'(xs_n - xs0), 1);
        chk(xs_f == {1'b0, 10'h123, 9'h1F5, 16'd3, 16'd2}, "R8 write fields", 64'(xs_f),
            64'({1'b0, 10'h123, 9'h1F5, 16'd3, 16'd2}));
        send(32'hDEAD_0001);
        send(32'hE100_0001);
        send(32'hBEEF_0003);
        idle(5);
        chk(xw_n - xw0 == 3, "R9 routed words", 64'(xw_n - xw0), 3);
        chk(xw_d[xw0+1] == 32'hE100_0001, "R9 routed data", 64'(xw_d[xw0+1]), 64'hE100_0001);
        chk(pk_n == base, "R8 R9 nothing framed", 64'(pk_n - base), 0);
        chk(stat_bits == 13'h1B23, "R9 payload no snoop", 64'(stat_bits), 64'h1B23);
        wv[0] = 32'hE100_0005;
        send_wv(1);
        expect_pkt(base, 1, "R9 framing resumes");
        chk(stat_bits == 13'h1805, "R9 R6 status", 64'(stat_bits), 64'h1805);
    endtask

    task automatic t_vram_odd();
        int xw0;
        xw0 = xw_n;
        send(32'hA000_0000);
        send(32'h0000_0000);
        send(32'h0001_0003);
        send(32'h1111_1111);
        send(32'h2222_2222);
        idle(3);
        chk(xw_n - xw0 == 2, "R9 odd pixel count", 64'(xw_n - xw0), 2);
        one_pkt(8'h44, 1, "R9 after odd transfer");
    endtask

    task automatic t_vram_read();
        int base, xs0, xw0;
        base = pk_n; xs0 = xs_n; xw0 = xw_n;
        send(32'hC000_0000);
        send(32'h0000_0010);
        send(32'h0004_0004);
        idle(3);
        chk(xs_n - xs0 == 1, "R8 read start pulse", 64'(xs_n - xs0), 1);
        chk(xs_f == {1'b1, 10'h010, 9'h000, 16'd4, 16'd4}, "R8 read fields", 64'(xs_f),
            64'({1'b1, 10'h010, 9'h000, 16'd4, 16'd4}));
        wv[0] = 32'hE600_0001;
        send_wv(1);
        expect_pkt(base, 1, "R9 read routes nothing");
        chk(xw_n == xw0, "R9 read no payload", 64'(xw_n - xw0), 0);
        chk(stat_bits == 13'h0805, "R7 status", 64'(stat_bits), 64'h0805);
    endtask

    task automatic t_vram_zero();
        int xw0;
        xw0 = xw_n;
        send(32'hA000_0000);
        send(32'h0000_0000);
        send(32'h0000_0005);
        one_pkt(8'h44, 1, "R9 zero-size write");
        chk(xw_n == xw0, "R9 zero-size no payload", 64'(xw_n - xw0), 0);
    endtask

    initial begin
        fork
            begin
                idle(4);
                rst = 1'b0;
                #1;
                t_reset();
                t_drawmode();
                t_mask();
                t_flat_poly();
                t_tex_flat();
                t_tex_shaded();
                t_hold();
                t_lengths();
                t_vram_write();
                t_vram_odd();
                t_vram_read();
                t_vram_zero();
            end
            begin
                idle(20000);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule